// File: doc/BRIEF.md
# Disk Controller Interrupt Cause Logic

This block collects the interrupt sources of a floppy-style disk controller, drives the single interrupt line to the host and reports why that line was raised. There are two classes of source. Data-phase sources are entry into the result phase and a transfer request made in programmed-I/O (non-DMA) mode. The host clears these by reading or writing the data register. Head-positioning sources are the end of a seek or recalibrate, normal or abnormal, and a change on a drive's ready line. They stay pending until the host issues a sense-interrupt command. Each sense command then returns a status byte whose top three bits give the cause class and whose low two bits give the drive number.

Seek-end causes for several drives can be pending at once. Each sense command reports one of them and clears only that one, so the host keeps issuing sense commands until the line falls. The block also drives the execution-phase flag of the main status byte. This flag is high during execution in programmed-I/O mode and falls when the result phase begins.

Top module: `fdc_irq_cause`

## Requirements
- R1: After reset, `irq` is 0, `exec_mode` is 0 and `st0_code` is 8'h00.
- R2: When `non_dma` is 1, an `exec_start` pulse sets `exec_mode` on the next clock. `result_enter` clears it on the next clock and takes precedence. When `non_dma` is 0, `exec_start` leaves `exec_mode` at 0.
- R3: `result_enter` raises `irq` on the next clock. A `data_access` pulse clears that cause with no sense command, and `irq` falls if nothing else is pending.
- R4: When `non_dma` is 1, `xfer_req` raises `irq` and `data_access` clears it. When `non_dma` is 0, `xfer_req` has no effect on `irq`.
- R5: A normal seek end (`seek_done` with `seek_abnormal`=0) for drive d raises `irq`. The next sense command loads `st0_code` = {3'b001, 3'b000, d}, so bits 7:5 = 001 and bits 1:0 = d.
- R6: An abnormal seek end for drive d is reported by sense as {3'b011, 3'b000, d}.
- R7: A ready-line change on drive d (`rdy_chg[d]`) is reported by sense as {3'b110, 3'b000, d}.
- R8: Each sense command reports and clears exactly one pending cause. Seek ends are reported before ready changes, and within each class the lowest drive number comes first. `irq` stays high while any cause is pending and falls after the last one is reported.
- R9: A sense command with no seek-end or ready-change cause pending loads `st0_code` = 8'h80 and leaves `irq` low.
- R10: A seek end and a ready change arriving on the same clock are both latched, and two successive sense commands report both.
- R11: A sense command does not clear a data-phase cause, and `data_access` does not clear a seek-end or ready-change cause. `st0_code` changes only on a clock where `sense_cmd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| non_dma | input | 1 | 1 = programmed-I/O mode, 0 = DMA mode |
| exec_start | input | 1 | Pulse at the start of a command's execution phase |
| result_enter | input | 1 | Pulse on entry into the result phase |
| xfer_req | input | 1 | Pulse requesting one data byte from the host |
| data_access | input | 1 | Pulse on a host read or write of the data register |
| seek_done | input | 1 | Pulse when a seek or recalibrate ends |
| seek_abnormal | input | 1 | Qualifies `seek_done`: 1 = abnormal end |
| seek_drive | input | 2 | Drive number that goes with `seek_done` |
| rdy_chg | input | NUM_DRIVES | Per-drive ready-line change pulses |
| sense_cmd | input | 1 | Pulse for a sense-interrupt command |
| irq | output | 1 | Interrupt line to the host |
| exec_mode | output | 1 | Execution-phase flag of the main status byte |
| st0_code | output | 8 | Status byte 0 loaded by the last sense command |

## Verification
On every cycle, the assertions check the execution flag against result entry and DMA mode, and the setting and clearing of the data-phase interrupt. They also check the empty-sense code, that a sense command serves seek ends before ready changes, that simultaneous events are both latched, and that the status byte holds between sense commands. Only the bench's scenarios can show the exact drive numbers in each code and the ascending order in which a queue of seek ends drains. They also show when the line falls after the last report and that the two interrupt classes clear independently.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;
  localparam int DRV_W = 2;
  localparam int MAX_DRIVES = 1 << DRV_W;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_SEEK_OK,
    CAUSE_SEEK_BAD,
    CAUSE_READY
  } cause_e;

  // Status byte 0: bits 7:5 carry the cause class, bits 1:0 carry the drive number.
  function automatic logic [7:0] st0_encode(cause_e kind, logic [DRV_W-1:0] drv);
    logic [7:0] code;
    case (kind)
      CAUSE_SEEK_OK:  code = {3'b001, 3'b000, drv};
      CAUSE_SEEK_BAD: code = {3'b011, 3'b000, drv};
      CAUSE_READY:    code = {3'b110, 3'b000, drv};
      default:        code = 8'h80;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/fdc_irq_data_ctl.sv
module fdc_irq_data_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic non_dma,
  input  logic exec_start,
  input  logic result_enter,
  input  logic xfer_req,
  input  logic data_access,
  output logic exec_mode,
  output logic data_pend
);
  logic data_set;
  assign data_set = result_enter | (xfer_req & non_dma);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_mode <= 1'b0;
      data_pend <= 1'b0;
    end else begin
      if (result_enter)                exec_mode <= 1'b0;
      else if (exec_start && non_dma)  exec_mode <= 1'b1;

      // A new request in the same cycle as an access survives.
      if (data_set)          data_pend <= 1'b1;
      else if (data_access)  data_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_irq_seek_bank.sv
module fdc_irq_seek_bank
  import fdc_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seek_done,
  input  logic                  seek_abnormal,
  input  logic [DRV_W-1:0]      seek_drive,
  input  logic [NUM_DRIVES-1:0] clr,
  output logic [NUM_DRIVES-1:0] pend,
  output logic [NUM_DRIVES-1:0] abn
);
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic set_d;
    assign set_d = seek_done && (seek_drive == DRV_W'(d));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[d] <= 1'b0;
        abn[d]  <= 1'b0;
      end else begin
        pend[d] <= (pend[d] & ~clr[d]) | set_d;
        if (set_d) abn[d] <= seek_abnormal;
      end
    end
  end
endmodule

// File: rtl/fdc_irq_ready_bank.sv
module fdc_irq_ready_bank #(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_DRIVES-1:0] rdy_chg,
  input  logic [NUM_DRIVES-1:0] clr,
  output logic [NUM_DRIVES-1:0] pend
);
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n) pend[d] <= 1'b0;
      else        pend[d] <= (pend[d] & ~clr[d]) | rdy_chg[d];
    end
  end
endmodule

// File: rtl/fdc_irq_arbiter.sv
module fdc_irq_arbiter
  import fdc_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  sense_cmd,
  input  logic [NUM_DRIVES-1:0] seek_pend,
  input  logic [NUM_DRIVES-1:0] seek_abn,
  input  logic [NUM_DRIVES-1:0] rdy_pend,
  output cause_e                kind,
  output logic [DRV_W-1:0]      drv,
  output logic [NUM_DRIVES-1:0] seek_clr,
  output logic [NUM_DRIVES-1:0] rdy_clr
);
  logic             seek_hit, rdy_hit;
  logic [DRV_W-1:0] seek_idx, rdy_idx;

  // Scan downward so the lowest set index is the one kept.
  always_comb begin
    seek_hit = 1'b0;
    seek_idx = '0;
    rdy_hit  = 1'b0;
    rdy_idx  = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (seek_pend[i]) begin
        seek_hit = 1'b1;
        seek_idx = DRV_W'(i);
      end
      if (rdy_pend[i]) begin
        rdy_hit = 1'b1;
        rdy_idx = DRV_W'(i);
      end
    end
  end

  always_comb begin
    seek_clr = '0;
    rdy_clr  = '0;
    if (seek_hit) begin
      kind = seek_abn[seek_idx] ? CAUSE_SEEK_BAD : CAUSE_SEEK_OK;
      drv  = seek_idx;
      seek_clr[seek_idx] = sense_cmd;
    end else if (rdy_hit) begin
      kind = CAUSE_READY;
      drv  = rdy_idx;
      rdy_clr[rdy_idx] = sense_cmd;
    end else begin
      kind = CAUSE_NONE;
      drv  = '0;
    end
  end
endmodule

// File: rtl/fdc_irq_cause.sv
module fdc_irq_cause
  import fdc_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  non_dma,
  input  logic                  exec_start,
  input  logic                  result_enter,
  input  logic                  xfer_req,
  input  logic                  data_access,
  input  logic                  seek_done,
  input  logic                  seek_abnormal,
  input  logic [DRV_W-1:0]      seek_drive,
  input  logic [NUM_DRIVES-1:0] rdy_chg,
  input  logic                  sense_cmd,
  output logic                  irq,
  output logic                  exec_mode,
  output logic [7:0]            st0_code
);
  logic                  data_pend;
  logic [NUM_DRIVES-1:0] seek_pend, seek_abn, seek_clr;
  logic [NUM_DRIVES-1:0] rdy_pend, rdy_clr;
  cause_e                kind;
  logic [DRV_W-1:0]      drv;

  fdc_irq_data_ctl u_data (
    .clk(clk), .rst_n(rst_n), .non_dma(non_dma), .exec_start(exec_start),
    .result_enter(result_enter), .xfer_req(xfer_req), .data_access(data_access),
    .exec_mode(exec_mode), .data_pend(data_pend)
  );

  fdc_irq_seek_bank #(.NUM_DRIVES(NUM_DRIVES)) u_seek (
    .clk(clk), .rst_n(rst_n), .seek_done(seek_done), .seek_abnormal(seek_abnormal),
    .seek_drive(seek_drive), .clr(seek_clr), .pend(seek_pend), .abn(seek_abn)
  );

  fdc_irq_ready_bank #(.NUM_DRIVES(NUM_DRIVES)) u_ready (
    .clk(clk), .rst_n(rst_n), .rdy_chg(rdy_chg), .clr(rdy_clr), .pend(rdy_pend)
  );

  fdc_irq_arbiter #(.NUM_DRIVES(NUM_DRIVES)) u_arb (
    .sense_cmd(sense_cmd), .seek_pend(seek_pend), .seek_abn(seek_abn),
    .rdy_pend(rdy_pend), .kind(kind), .drv(drv),
    .seek_clr(seek_clr), .rdy_clr(rdy_clr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         st0_code <= 8'h00;
    else if (sense_cmd) st0_code <= st0_encode(kind, drv);
  end

  assign irq = data_pend | (|seek_pend) | (|rdy_pend);
endmodule

// File: rtl/fdc_irq_cause_chk.sv
module fdc_irq_cause_chk #(
  parameter int NUM_DRIVES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  non_dma,
  input logic                  exec_start,
  input logic                  result_enter,
  input logic                  xfer_req,
  input logic                  data_access,
  input logic                  seek_done,
  input logic [NUM_DRIVES-1:0] rdy_chg,
  input logic                  sense_cmd,
  input logic                  irq,
  input logic                  exec_mode,
  input logic [7:0]            st0_code,
  input logic [NUM_DRIVES-1:0] seek_pend,
  input logic [NUM_DRIVES-1:0] rdy_pend
);
  p_exec_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    result_enter |=> !exec_mode);

  p_dma_no_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!non_dma && !exec_mode) |=> !exec_mode);

  p_data_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_enter |=> irq);

  p_data_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_access && !result_enter && !(xfer_req && non_dma) && !seek_done &&
     rdy_chg == '0 && seek_pend == '0 && rdy_pend == '0) |=> !irq);

  p_seek_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_cmd && seek_pend != '0) |=> (!st0_code[7] && st0_code[5]));

  p_empty_sense_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_cmd && seek_pend == '0 && rdy_pend == '0) |=> st0_code == 8'h80);

  p_both_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_done && rdy_chg != '0) |=> (seek_pend != '0 && rdy_pend != '0));

  p_st0_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_cmd |=> $stable(st0_code));
endmodule

bind fdc_irq_cause fdc_irq_cause_chk #(.NUM_DRIVES(NUM_DRIVES)) u_chk (.*);

// File: tb/fdc_irq_cause_test.sv
module fdc_irq_cause_test;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          non_dma = 1'b0, exec_start = 1'b0, result_enter = 1'b0;
  logic          xfer_req = 1'b0, data_access = 1'b0, seek_done = 1'b0;
  logic          seek_abnormal = 1'b0, sense_cmd = 1'b0;
  logic [1:0]    seek_drive = 2'd0;
  logic [ND-1:0] rdy_chg = '0;
  logic          irq, exec_mode;
  logic [7:0]    st0_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fdc_irq_cause #(.NUM_DRIVES(ND)) uut (
    .clk(clk), .rst_n(rst_n), .non_dma(non_dma), .exec_start(exec_start),
    .result_enter(result_enter), .xfer_req(xfer_req), .data_access(data_access),
    .seek_done(seek_done), .seek_abnormal(seek_abnormal), .seek_drive(seek_drive),
    .rdy_chg(rdy_chg), .sense_cmd(sense_cmd), .irq(irq), .exec_mode(exec_mode),
    .st0_code(st0_code)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Inputs change on the falling edge, so the state is settled one falling edge later.
  task automatic step();
    @(negedge clk);
    exec_start = 0; result_enter = 0; xfer_req = 0; data_access = 0;
    seek_done = 0; seek_abnormal = 0; rdy_chg = '0; sense_cmd = 0;
  endtask

  task automatic seek(logic [1:0] d, logic bad);
    seek_done = 1; seek_drive = d; seek_abnormal = bad; step();
  endtask

  task automatic sense(string req, logic [7:0] exp, logic irq_exp);
    sense_cmd = 1; step();
    chk(req, st0_code, exp);
    chk(req, {7'd0, irq}, {7'd0, irq_exp});
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 exec_mode", {7'd0, exec_mode}, 8'd0);
    chk("R1 st0", st0_code, 8'h00);
  endtask

  task automatic t_exec();
    non_dma = 1; exec_start = 1; step();
    chk("R2 exec set", {7'd0, exec_mode}, 8'd1);
    result_enter = 1; step();
    chk("R2 exec clear", {7'd0, exec_mode}, 8'd0);
    chk("R3 irq on result", {7'd0, irq}, 8'd1);
    data_access = 1; step();
    chk("R3 irq cleared by access", {7'd0, irq}, 8'd0);
    non_dma = 0; exec_start = 1; step();
    chk("R2 dma no exec", {7'd0, exec_mode}, 8'd0);
  endtask

  task automatic t_xfer();
    non_dma = 1; xfer_req = 1; step();
    chk("R4 xfer irq", {7'd0, irq}, 8'd1);
    data_access = 1; step();
    chk("R4 xfer cleared", {7'd0, irq}, 8'd0);
    non_dma = 0; xfer_req = 1; step();
    chk("R4 dma xfer ignored", {7'd0, irq}, 8'd0);
  endtask

  task automatic t_seek_codes();
    seek(2'd2, 1'b0);
    chk("R5 seek irq", {7'd0, irq}, 8'd1);
    sense("R5 normal drv2", 8'h22, 1'b0);
    seek(2'd1, 1'b1);
    sense("R6 abnormal drv1", 8'h61, 1'b0);
    rdy_chg = 4'b1000; step();
    chk("R7 ready irq", {7'd0, irq}, 8'd1);
    sense("R7 ready drv3", 8'hC3, 1'b0);
  endtask

  task automatic t_queue();
    seek(2'd3, 1'b0);
    seek(2'd0, 1'b0);
    seek(2'd2, 1'b1);
    sense("R8 first drv0", 8'h20, 1'b1);
    sense("R8 second drv2", 8'h62, 1'b1);
    sense("R8 last drv3", 8'h23, 1'b0);
  endtask

  task automatic t_empty();
    sense("R9 empty sense", 8'h80, 1'b0);
  endtask

  task automatic t_simul();
    seek_done = 1; seek_drive = 2'd1; rdy_chg = 4'b0010; step();
    sense("R10 seek part", 8'h21, 1'b1);
    sense("R10 ready part", 8'hC1, 1'b0);
  endtask

  task automatic t_indep();
    non_dma = 1; result_enter = 1; step();
    seek(2'd0, 1'b0);
    sense("R11 seek served", 8'h20, 1'b1);
    data_access = 1; step();
    chk("R11 data cleared", {7'd0, irq}, 8'd0);
    chk("R11 st0 held", st0_code, 8'h20);
    rdy_chg = 4'b0001; step();
    data_access = 1; step();
    chk("R11 access keeps ready", {7'd0, irq}, 8'd1);
    sense("R11 ready drained", 8'hC0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_exec();
    t_xfer();
    t_seek_codes();
    t_queue();
    t_empty();
    t_simul();
    t_indep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule